// File: doc/BRIEF.md
# Receive Tap Calibration Sequencer

This block selects the sampling delay of a serial receive link. Once started, it walks the four delay taps in turn. For each tap it drives the tap onto the delay line and issues a read of a fixed test register through a request/acknowledge port. It then compares the returned word with a known pattern. Each matching read marks that tap as good in a 4-bit pass mask.

When the last tap has been tried, the mask is resolved through a fixed window table. A contiguous group of good taps yields a final tap, which is driven onto the delay output, and `done_o` is raised. A mask with a gap, or with no good tap, raises `error_o` and leaves the delay output on the last tap swept.

The serial transport and the delay line sit outside the block. A new calibration is accepted only while the block is idle.

Top module: `rxcal_top`

## Requirements
- R1: After reset, `tap_o` is 0, `done_o`, `error_o` and `busy_o` are 0, `pass_mask_o` is 0 and no read is requested.
- R2: A calibration visits taps 0, 1, 2, 3 (0, 2, 4, 6 ns) in ascending order and issues exactly one read per tap to address `TEST_ADDR`. All four taps are always visited, even after a failing tap.
- R3: `rd_req_o` stays high and `tap_o` stays unchanged from the request until `rd_ack_i`. The next tap is not tried before the response arrives.
- R4: Bit i of `pass_mask_o` is 1 exactly when the word returned while `tap_o` was i equals 16'h5AA5.
- R5: Pass masks 0 through 15 resolve to final taps -,0,1,0,2,-,1,1,3,-,-,-,3,-,2,1. A mask with a number resolves to success: `tap_o` becomes that tap and `done_o` is set.
- R6: A mask marked "-" in that list (mask 0 included) resolves to failure: `error_o` is set, `done_o` stays 0 and `tap_o` stays at 3.
- R7: A start pulse while `busy_o` is 1 is ignored. The running sweep and its result are unchanged.
- R8: `done_o` and `error_o` are never both 1. Each holds until the next accepted start, which clears both flags and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Address of the test register |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | DATA_W | Read response word |
| tap_o | output | TAP_W | Delay tap driven to the delay line |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration succeeded; `tap_o` holds the chosen tap |
| error_o | output | 1 | Pass window not contiguous or empty |
| pass_mask_o | output | NUM_TAPS | Pass mask of the latest sweep |

## Verification
The bench drives all sixteen pass masks through a link model. Its scoreboard checks each outcome against the window table. Any error in the table, or any mixing up of the error and done cases, therefore shows up on a specific mask.

Sweeps with a slow responder check that the tap is held through the wait. A design that advanced early would sample the wrong tap and corrupt the mask.

Near-miss data words, each one bit away from the pattern, catch a compare that is only partial. A start pulse issued during a sweep catches a design that restarts, which would show up as extra tap visits. A rerun after a failure checks that the stale error flag is cleared.

// File: rtl/rxcal_pkg.sv
package rxcal_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_READ   = 2'd2,
      ST_DECIDE = 2'd3
   } cal_state_e;

   typedef struct packed {
      logic       ok;
      logic [1:0] tap;
   } window_res_t;

   // Contiguous windows resolve to a tap; gaps and the empty mask do not.
   function automatic window_res_t resolve_window(input logic [3:0] m);
      window_res_t r;
      r.ok  = 1'b1;
      r.tap = 2'd0;
      case (m)
         4'd1, 4'd3:                r.tap = 2'd0;
         4'd2, 4'd6, 4'd7, 4'd15:   r.tap = 2'd1;
         4'd4, 4'd14:               r.tap = 2'd2;
         4'd8, 4'd12:               r.tap = 2'd3;
         default:                   r.ok  = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rxcal_ctrl.sv
module rxcal_ctrl
   import rxcal_pkg::*;
#(
   parameter int NUM_TAPS = 4,
   localparam int TAP_W   = $clog2(NUM_TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             rd_ack_i,
   input  logic             res_ok_i,
   input  logic [TAP_W-1:0] res_tap_i,
   output logic             rd_req_o,
   output logic             clr_o,
   output logic             cap_o,
   output logic [TAP_W-1:0] tap_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             error_o
);
   localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

   cal_state_e       state_q;
   logic [TAP_W-1:0] tap_q;
   logic             done_q, err_q;

   assign clr_o    = (state_q == ST_IDLE) && start_i;
   assign cap_o    = (state_q == ST_READ) && rd_ack_i;
   assign rd_req_o = (state_q == ST_READ);
   assign busy_o   = (state_q != ST_IDLE);
   assign tap_o    = tap_q;
   assign done_o   = done_q;
   assign error_o  = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tap_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               tap_q   <= '0;
               done_q  <= 1'b0;
               err_q   <= 1'b0;
               state_q <= ST_SETTLE;
            end
            ST_SETTLE: state_q <= ST_READ;
            ST_READ: if (rd_ack_i) begin
               if (tap_q == LAST_TAP) begin
                  state_q <= ST_DECIDE;
               end else begin
                  tap_q   <= tap_q + 1'b1;
                  state_q <= ST_SETTLE;
               end
            end
            ST_DECIDE: begin
               if (res_ok_i) begin
                  tap_q  <= res_tap_i;
                  done_q <= 1'b1;
               end else begin
                  err_q  <= 1'b1;
               end
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxcal_mask.sv
module rxcal_mask #(
   parameter int          NUM_TAPS = 4,
   parameter int          DATA_W   = 16,
   parameter logic [DATA_W-1:0] PATTERN = 16'h5AA5,
   localparam int         TAP_W    = $clog2(NUM_TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              cap_i,
   input  logic [TAP_W-1:0]  tap_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [NUM_TAPS-1:0] mask_o
);
   logic hit;
   assign hit = (data_i == PATTERN);

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                bit_q <= 1'b0;
         else if (clr_i)                            bit_q <= 1'b0;
         else if (cap_i && (tap_i == TAP_W'(i)))    bit_q <= hit;
      end
      assign mask_o[i] = bit_q;
   end
endmodule

// File: rtl/rxcal_resolve.sv
module rxcal_resolve
   import rxcal_pkg::*;
#(
   parameter int NUM_TAPS = 4,
   localparam int TAP_W   = $clog2(NUM_TAPS)
) (
   input  logic [NUM_TAPS-1:0] mask_i,
   output logic                ok_o,
   output logic [TAP_W-1:0]    tap_o
);
   window_res_t res;
   always_comb res = resolve_window(mask_i);
   assign ok_o  = res.ok;
   assign tap_o = res.tap;
endmodule

// File: rtl/rxcal_top.sv
module rxcal_top #(
   parameter int                NUM_TAPS  = 4,
   parameter int                DATA_W    = 16,
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] TEST_ADDR = 16'h000A,
   parameter logic [DATA_W-1:0] PATTERN   = 16'h5AA5,
   localparam int               TAP_W     = $clog2(NUM_TAPS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   output logic                rd_req_o,
   output logic [ADDR_W-1:0]   rd_addr_o,
   input  logic                rd_ack_i,
   input  logic [DATA_W-1:0]   rd_data_i,
   output logic [TAP_W-1:0]    tap_o,
   output logic                busy_o,
   output logic                done_o,
   output logic                error_o,
   output logic [NUM_TAPS-1:0] pass_mask_o
);
   if (NUM_TAPS != 4) begin : g_bad_taps
      $error("rxcal_top: window table is defined for exactly 4 taps");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("rxcal_top: widths must be positive");
   end

   logic             clr, cap, res_ok;
   logic [TAP_W-1:0] res_tap;

   assign rd_addr_o = TEST_ADDR;

   rxcal_ctrl #(.NUM_TAPS(NUM_TAPS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_ack_i(rd_ack_i),
      .res_ok_i(res_ok), .res_tap_i(res_tap), .rd_req_o(rd_req_o),
      .clr_o(clr), .cap_o(cap), .tap_o(tap_o), .busy_o(busy_o),
      .done_o(done_o), .error_o(error_o)
   );

   rxcal_mask #(.NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W), .PATTERN(PATTERN)) u_mask (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .cap_i(cap), .tap_i(tap_o),
      .data_i(rd_data_i), .mask_o(pass_mask_o)
   );

   rxcal_resolve #(.NUM_TAPS(NUM_TAPS)) u_res (
      .mask_i(pass_mask_o), .ok_o(res_ok), .tap_o(res_tap)
   );
endmodule

// File: rtl/rxcal_chk.sv
module rxcal_chk #(
   parameter int NUM_TAPS = 4,
   localparam int TAP_W   = $clog2(NUM_TAPS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic                rd_req_o,
   input logic                rd_ack_i,
   input logic [TAP_W-1:0]    tap_o,
   input logic                busy_o,
   input logic                done_o,
   input logic                error_o,
   input logic [NUM_TAPS-1:0] pass_mask_o
);
   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && !rd_ack_i |=> rd_req_o && $stable(tap_o));

   // R2
   tap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) && (tap_o != $past(tap_o)) |-> tap_o == $past(tap_o) + 1'b1);

   // R5
   done_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> pass_mask_o != '0);

   // R6
   err_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error_o) |-> tap_o == TAP_W'(NUM_TAPS - 1));

   // R8
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && error_o));

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> done_o);

   // R1
   idle_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_req_o);
endmodule

bind rxcal_top rxcal_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
   .rd_ack_i(rd_ack_i), .tap_o(tap_o), .busy_o(busy_o), .done_o(done_o),
   .error_o(error_o), .pass_mask_o(pass_mask_o)
);

// File: tb/tb_rxcal_top.sv
module tb_rxcal_top;
   localparam logic [15:0] PAT  = 16'h5AA5;
   localparam logic [15:0] ADDR = 16'h000A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rd_req_o, rd_ack_i = 1'b0;
   logic [15:0] rd_addr_o, rd_data_i = '0;
   logic [1:0]  tap_o;
   logic        busy_o, done_o, error_o;
   logic [3:0]  pass_mask_o;

   always #5 clk = ~clk;

   rxcal_top dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
      .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
      .tap_o(tap_o), .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
      .pass_mask_o(pass_mask_o)
   );

   typedef struct { int tap; bit done; bit err; logic [3:0] mask; } exp_t;
   exp_t exp_q[$];
   int   visits[$];
   int   n_chk = 0, n_fail = 0;
   bit   finished = 0;

   logic [3:0] good_taps = '0;
   int         lat = 0;
   int         wait_cnt = 0;
   int         held_tap = -1;

   // R5 R6: final tap by mask, -1 marks a broken window
   int win_tab[16] = '{-1,0,1,0,2,-1,1,1,3,-1,-1,-1,3,-1,2,1};

   task automatic chk(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Link model: answers each request after lat cycles
   initial begin
      forever begin
         @(negedge clk);
         if (rd_ack_i) begin
            rd_ack_i = 1'b0;
         end else if (rd_req_o) begin
            if (held_tap < 0) held_tap = int'(tap_o);
            // R3: tap must not move while the read is outstanding
            if (int'(tap_o) != held_tap)
               chk(0, "R3", "tap moved during read", int'(tap_o), held_tap);
            // R2: address of the test register
            if (rd_addr_o != ADDR)
               chk(0, "R2", "read address", int'(rd_addr_o), int'(ADDR));
            if (wait_cnt >= lat) begin
               rd_ack_i  = 1'b1;
               rd_data_i = good_taps[tap_o] ? PAT : (PAT ^ (16'h1 << (4*tap_o + 1)));
               visits.push_back(int'(tap_o));
               wait_cnt  = 0;
               held_tap  = -1;
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   // Scoreboard monitor
   bit fin_prev = 0;
   always @(negedge clk) begin
      bit fin;
      fin = done_o | error_o;
      if (rst_n && fin && !fin_prev) begin
         if (exp_q.size() == 0) begin
            chk(0, "R8", "unexpected completion", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(pass_mask_o == e.mask, "R4", "pass mask", int'(pass_mask_o), int'(e.mask));
            chk(done_o == e.done, e.done ? "R5" : "R6", "done flag", int'(done_o), int'(e.done));
            chk(error_o == e.err, e.err ? "R6" : "R5", "error flag", int'(error_o), int'(e.err));
            chk(int'(tap_o) == e.tap, e.err ? "R6" : "R5", "final tap", int'(tap_o), e.tap);
         end
      end
      fin_prev = fin;
   end

   task automatic run_cal(logic [3:0] good, int latency, bit poke_busy);
      exp_t e;
      int   guard;
      good_taps = good;
      lat       = latency;
      visits.delete();
      e.mask = good;
      e.done = (win_tab[good] >= 0);
      e.err  = !e.done;
      e.tap  = e.done ? win_tab[good] : 3;
      exp_q.push_back(e);
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      // R8: an accepted start clears the previous result flags
      chk(!done_o && !error_o, "R8", "flags cleared on start", int'(done_o | error_o), 0);
      if (poke_busy) begin
         repeat (3) @(negedge clk);
         // R7: start while busy must be ignored
         start_i = 1'b1;
         @(negedge clk); start_i = 1'b0;
      end
      guard = 0;
      while (!(done_o || error_o) && guard < 500) begin
         @(negedge clk); guard++;
      end
      repeat (2) @(negedge clk);
      chk(visits.size() == 4, poke_busy ? "R7" : "R2", "tap visits", visits.size(), 4);
      for (int k = 0; k < visits.size() && k < 4; k++)
         chk(visits[k] == k, "R2", "sweep order", visits[k], k);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(tap_o == 0 && !done_o && !error_o && !busy_o && pass_mask_o == 0 && !rd_req_o,
          "R1", "reset outputs", int'({tap_o, done_o, error_o, busy_o, pass_mask_o, rd_req_o}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!rd_req_o && !busy_o, "R1", "idle after reset", int'(rd_req_o), 0);

      for (int m = 0; m < 16; m++) run_cal(4'(m), 0, 0);
      run_cal(4'b0110, 3, 0);   // R3 slow responder
      run_cal(4'b1010, 2, 0);   // R6 with waits
      run_cal(4'b1100, 1, 1);   // R7 start while busy
      run_cal(4'b0000, 0, 0);   // R6 all fail
      run_cal(4'b1111, 0, 0);   // R8 rerun after error clears it

      // R8: done holds with no new start
      repeat (6) @(negedge clk);
      chk(done_o && !error_o, "R8", "done held", int'(done_o), 1);
      chk(int'(tap_o) == 1, "R8", "tap held", int'(tap_o), 1);

      chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule